// File: doc/BRIEF.md
# USB device interrupt aggregator

This block gathers the event pulses produced by a USB device controller into one status word that software can read, and turns that word into a single interrupt line. Each source has an enable bit; a flag stays set until software writes a 1 to its bit position. The sources are bus events (suspend or resume), transaction events, VBUS attach or detach changes, wake-ups with no bus event, and received SETUP packets.

A transaction event arrives with the endpoint index it concerns, a 3-bit result code and an overrun bit. An accepted transaction raises the summary transaction flag and the flag of its endpoint. It also records its code in that endpoint's slot of a packed, read-only endpoint status word, and records index, code and overrun as the "most recent transaction" fields of that word. A control bit decides whether a NAK answered to an IN token counts as a transaction at all.

Software reaches the block through a word-wide register port with a 2-bit word select. Writes take effect at the clock edge and reads are combinational.

Top module: `usbd_irq_agg`

## Requirements
- R1: After reset the enable word, the status word and the endpoint status word all read 0 and `irq` is low.
- R2: Word 0 is the enable word. Bit 0 enables bus events, bit 1 transaction events, bit 2 VBUS changes and bit 3 no-event wake-ups. Bit 8 is a stored wake-up function enable and bit 15 is the NAK-report control. All other bits read 0.
- R3: Word 1 is the status word. A pulse on `ev_bus`, `ev_vbus`, `ev_wake` or `ev_setup` sets bit 0, 2, 3 or 31 in turn. An accepted transaction sets bit 1 and, for endpoint index n below NUM_EP, bit 16+n.
- R4: Writing 1 to a status bit clears that flag. Writing 0 leaves it unchanged.
- R5: Writing 1 to status bit 1 also clears every endpoint flag. Writing 1 to bit 16+n clears only endpoint n's flag.
- R6: When an event that sets a flag arrives in the same cycle as a write-1 clear of that flag, the flag is set after the edge.
- R7: Word 2 is the endpoint status word. Bits [3:0] hold the index of the most recent accepted transaction, [6:4] its code and bit 7 its overrun bit. Bits [8+3n+2:8+3n] hold the most recent code for endpoint n. The codes are 000 IN ACK, 001 IN NAK, 010 OUT DATA0 ACK, 011 SETUP ACK, 110 OUT DATA1 ACK and 111 isochronous end.
- R8: While enable bit 15 is 0, a transaction with code 001 is dropped: no flag and no field changes. While bit 15 is 1, it is accepted like any other code.
- R9: `irq` is the OR of bus, VBUS and wake-up flags ANDed with their own enables, and of the transaction, endpoint and setup flags ANDed with enable bit 1. It is driven from registered state, so it follows an event in the cycle after the edge that captured it.
- R10: Writes to word 2 change nothing. Word 3 reads 0.
- R11: A transaction whose index is NUM_EP or above sets bit 1 and updates bits [7:0] of word 2, but sets no endpoint flag and changes no endpoint slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select (0 enable, 1 status, 2 endpoint status) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word |
| ev_bus | input | 1 | Bus event pulse |
| ev_vbus | input | 1 | VBUS attach/detach change pulse |
| ev_wake | input | 1 | No-event wake-up pulse |
| ev_setup | input | 1 | SETUP received pulse |
| ev_xfer | input | 1 | Transaction event pulse |
| ev_ep | input | EPIDX_W | Endpoint index of the transaction |
| ev_code | input | CODE_W | Result code of the transaction |
| ev_ovr | input | 1 | Overrun bit of the transaction |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: NUM_EP=6, EPIDX_W=4 and CODE_W=3. With these values the random endpoint indices 6 and 7 land beyond the endpoint count, so the out-of-range path runs. The 3-bit code width also lets the two unassigned codes reach the endpoint slots. Six slots of three bits fill word 2 up to bit 25, so the highest slot is compared alongside the fixed low fields.

// File: rtl/usbd_irq_pkg.sv
package usbd_irq_pkg;

    localparam int REG_W = 32;

    // word select values
    localparam logic [1:0] A_ENABLE = 2'd0;
    localparam logic [1:0] A_STATUS = 2'd1;
    localparam logic [1:0] A_EPWORD = 2'd2;

    // enable word bit positions
    localparam int B_EN_BUS  = 0;
    localparam int B_EN_USB  = 1;
    localparam int B_EN_VBUS = 2;
    localparam int B_EN_WAKE = 3;
    localparam int B_EN_WKFN = 8;
    localparam int B_EN_NAK  = 15;

    // status word bit positions
    localparam int B_F_BUS   = 0;
    localparam int B_F_USB   = 1;
    localparam int B_F_VBUS  = 2;
    localparam int B_F_WAKE  = 3;
    localparam int B_F_EP0   = 16;
    localparam int B_F_SETUP = 31;

    typedef enum logic [2:0] {
        CODE_IN_ACK    = 3'b000,
        CODE_IN_NAK    = 3'b001,
        CODE_OUT0_ACK  = 3'b010,
        CODE_SETUP_ACK = 3'b011,
        CODE_OUT1_ACK  = 3'b110,
        CODE_ISO_END   = 3'b111
    } xfer_code_e;

endpackage

// File: rtl/usbd_irq_evfilt.sv
module usbd_irq_evfilt
    import usbd_irq_pkg::*;
#(
    parameter int NUM_EP  = 6,
    parameter int EPIDX_W = 4,
    parameter int CODE_W  = 3
) (
    input  logic               xfer_vld,
    input  logic [EPIDX_W-1:0] xfer_ep,
    input  logic [CODE_W-1:0]  xfer_code,
    input  logic               nak_rpt,
    output logic               accept,
    output logic [NUM_EP-1:0]  ep_hit
);

    logic is_nak;

    assign is_nak = (xfer_code == CODE_W'(CODE_IN_NAK));
    assign accept = xfer_vld && !(is_nak && !nak_rpt);

    for (genvar i = 0; i < NUM_EP; i++) begin : g_hit
        assign ep_hit[i] = accept && (xfer_ep == EPIDX_W'(i));
    end

endmodule

// File: rtl/usbd_irq_epbank.sv
module usbd_irq_epbank #(
    parameter int NUM_EP = 6,
    parameter int CODE_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_EP-1:0]        ep_hit,
    input  logic [CODE_W-1:0]        set_code,
    input  logic                     clr_all,
    input  logic [NUM_EP-1:0]        clr_one,
    output logic [NUM_EP-1:0]        ep_flags,
    output logic [NUM_EP*CODE_W-1:0] ep_codes
);

    typedef struct packed {
        logic [NUM_EP-1:0]             flg;
        logic [NUM_EP-1:0][CODE_W-1:0] code;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        for (int i = 0; i < NUM_EP; i++) begin
            b_d.flg[i] = ep_hit[i] | (b_q.flg[i] & ~clr_all & ~clr_one[i]);
            if (ep_hit[i]) begin
                b_d.code[i] = set_code;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign ep_flags = b_q.flg;

    for (genvar i = 0; i < NUM_EP; i++) begin : g_code
        assign ep_codes[i*CODE_W +: CODE_W] = b_q.code[i];
    end

endmodule

// File: rtl/usbd_irq_agg.sv
module usbd_irq_agg
    import usbd_irq_pkg::*;
#(
    parameter int NUM_EP  = 6,
    parameter int EPIDX_W = 4,
    parameter int CODE_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               ev_bus,
    input  logic               ev_vbus,
    input  logic               ev_wake,
    input  logic               ev_setup,
    input  logic               ev_xfer,
    input  logic [EPIDX_W-1:0] ev_ep,
    input  logic [CODE_W-1:0]  ev_code,
    input  logic               ev_ovr,
    output logic               irq
);

    localparam int LAST_W = EPIDX_W + CODE_W + 1;
    localparam int PACK_W = LAST_W + CODE_W * NUM_EP;

    typedef struct packed {
        logic               en_bus;
        logic               en_usb;
        logic               en_vbus;
        logic               en_wake;
        logic               en_wkfn;
        logic               en_nak;
        logic               f_bus;
        logic               f_usb;
        logic               f_vbus;
        logic               f_wake;
        logic               f_setup;
        logic [EPIDX_W-1:0] last_ep;
        logic [CODE_W-1:0]  last_code;
        logic               last_ovr;
    } agg_t;

    agg_t s_d, s_q;

    logic                     wr_en, wr_st;
    logic                     xfer_ok;
    logic [NUM_EP-1:0]        ep_hit;
    logic [NUM_EP-1:0]        ep_flags;
    logic [NUM_EP*CODE_W-1:0] ep_codes;
    logic [REG_W-1:0]         en_word, sts_word, epw_word;
    logic                     wdata_unused;

    assign wr_en        = reg_wr && (reg_addr == A_ENABLE);
    assign wr_st        = reg_wr && (reg_addr == A_STATUS);
    assign wdata_unused = ^reg_wdata;

    usbd_irq_evfilt #(
        .NUM_EP (NUM_EP),
        .EPIDX_W(EPIDX_W),
        .CODE_W (CODE_W)
    ) filt_i (
        .xfer_vld (ev_xfer),
        .xfer_ep  (ev_ep),
        .xfer_code(ev_code),
        .nak_rpt  (s_q.en_nak),
        .accept   (xfer_ok),
        .ep_hit   (ep_hit)
    );

    usbd_irq_epbank #(
        .NUM_EP(NUM_EP),
        .CODE_W(CODE_W)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ep_hit  (ep_hit),
        .set_code(ev_code),
        .clr_all (wr_st && reg_wdata[B_F_USB]),
        .clr_one (wr_st ? reg_wdata[B_F_EP0 +: NUM_EP] : '0),
        .ep_flags(ep_flags),
        .ep_codes(ep_codes)
    );

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.en_bus  = reg_wdata[B_EN_BUS];
            s_d.en_usb  = reg_wdata[B_EN_USB];
            s_d.en_vbus = reg_wdata[B_EN_VBUS];
            s_d.en_wake = reg_wdata[B_EN_WAKE];
            s_d.en_wkfn = reg_wdata[B_EN_WKFN];
            s_d.en_nak  = reg_wdata[B_EN_NAK];
        end
        // a new event outranks a clear in the same cycle
        s_d.f_bus   = ev_bus   | (s_q.f_bus   & ~(wr_st && reg_wdata[B_F_BUS]));
        s_d.f_usb   = xfer_ok  | (s_q.f_usb   & ~(wr_st && reg_wdata[B_F_USB]));
        s_d.f_vbus  = ev_vbus  | (s_q.f_vbus  & ~(wr_st && reg_wdata[B_F_VBUS]));
        s_d.f_wake  = ev_wake  | (s_q.f_wake  & ~(wr_st && reg_wdata[B_F_WAKE]));
        s_d.f_setup = ev_setup | (s_q.f_setup & ~(wr_st && reg_wdata[B_F_SETUP]));
        if (xfer_ok) begin
            s_d.last_ep   = ev_ep;
            s_d.last_code = ev_code;
            s_d.last_ovr  = ev_ovr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        en_word            = '0;
        en_word[B_EN_BUS]  = s_q.en_bus;
        en_word[B_EN_USB]  = s_q.en_usb;
        en_word[B_EN_VBUS] = s_q.en_vbus;
        en_word[B_EN_WAKE] = s_q.en_wake;
        en_word[B_EN_WKFN] = s_q.en_wkfn;
        en_word[B_EN_NAK]  = s_q.en_nak;

        sts_word                      = '0;
        sts_word[B_F_BUS]             = s_q.f_bus;
        sts_word[B_F_USB]             = s_q.f_usb;
        sts_word[B_F_VBUS]            = s_q.f_vbus;
        sts_word[B_F_WAKE]            = s_q.f_wake;
        sts_word[B_F_EP0 +: NUM_EP]   = ep_flags;
        sts_word[B_F_SETUP]           = s_q.f_setup;

        epw_word             = '0;
        epw_word[PACK_W-1:0] = {ep_codes, s_q.last_ovr, s_q.last_code, s_q.last_ep};
    end

    always_comb begin
        case (reg_addr)
            A_ENABLE: reg_rdata = en_word;
            A_STATUS: reg_rdata = sts_word;
            A_EPWORD: reg_rdata = epw_word;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = (s_q.f_bus  & s_q.en_bus)
               | (s_q.f_vbus & s_q.en_vbus)
               | (s_q.f_wake & s_q.en_wake)
               | ((s_q.f_usb | (|ep_flags) | s_q.f_setup) & s_q.en_usb);

endmodule

// File: rtl/usbd_irq_agg_chk.sv
module usbd_irq_agg_chk
    import usbd_irq_pkg::*;
#(
    parameter int NUM_EP = 6,
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              ev_bus,
    input logic              ev_xfer,
    input logic [CODE_W-1:0] ev_code,
    input logic              irq,
    input logic [REG_W-1:0]  en_word,
    input logic [REG_W-1:0]  sts_word,
    input logic [REG_W-1:0]  epw_word
);

    // R6
    bus_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bus |=> sts_word[B_F_BUS]);

    // R4
    bus_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == A_STATUS && reg_wdata[B_F_BUS] && !ev_bus
        |=> !sts_word[B_F_BUS]);

    // R4
    sts_wr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == A_STATUS && reg_wdata == '0
        |=> (sts_word & $past(sts_word)) == $past(sts_word));

    // R5
    usb_clr_eps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == A_STATUS && reg_wdata[B_F_USB] && !ev_xfer
        |=> sts_word[B_F_EP0 +: NUM_EP] == '0);

    // R8
    nak_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_xfer && ev_code == CODE_W'(CODE_IN_NAK) && !en_word[B_EN_NAK]
        |=> $stable(epw_word));

    // R10
    epw_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == A_EPWORD && !ev_xfer |=> $stable(epw_word));

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_word[3:0] == 4'd0 |-> !irq);

endmodule

bind usbd_irq_agg usbd_irq_agg_chk #(
    .NUM_EP(NUM_EP),
    .CODE_W(CODE_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .ev_bus   (ev_bus),
    .ev_xfer  (ev_xfer),
    .ev_code  (ev_code),
    .irq      (irq),
    .en_word  (en_word),
    .sts_word (sts_word),
    .epw_word (epw_word)
);

// File: tb/usbd_irq_agg_tb.sv
`timescale 1ns/1ps
module usbd_irq_agg_tb_top;

    localparam int NEP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_bus = 1'b0, ev_vbus = 1'b0, ev_wake = 1'b0, ev_setup = 1'b0;
    logic        ev_xfer = 1'b0, ev_ovr = 1'b0;
    logic [3:0]  ev_ep = '0;
    logic [2:0]  ev_code = '0;
    logic        irq;

    int ntot = 0;
    int nbad = 0;
    bit done = 1'b0;

    logic [31:0] m_en = '0, m_sts = '0, m_epw = '0;

    always #2 clk = ~clk;

    usbd_irq_agg dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_bus(ev_bus),
        .ev_vbus(ev_vbus), .ev_wake(ev_wake), .ev_setup(ev_setup),
        .ev_xfer(ev_xfer), .ev_ep(ev_ep), .ev_code(ev_code), .ev_ovr(ev_ovr),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        ntot++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.1;
        v = reg_rdata;
    endtask

    function automatic logic exp_irq();
        return (|(m_sts[3:0] & m_en[3:0])) |
               (((|m_sts[16 +: NEP]) | m_sts[31]) & m_en[1]);
    endfunction

    // expected next state from the inputs held across the edge
    task automatic model_step();
        logic [31:0] clr, ns, ne, nw;
        logic ok;
        ok  = ev_xfer && !(ev_code == 3'b001 && !m_en[15]);
        clr = (reg_wr && reg_addr == 2'd1) ? reg_wdata : 32'h0;
        ne  = (reg_wr && reg_addr == 2'd0) ? (reg_wdata & 32'h0000_810F) : m_en;
        ns  = m_sts;
        ns[0]  = ev_bus   | (m_sts[0]  & ~clr[0]);
        ns[1]  = ok       | (m_sts[1]  & ~clr[1]);
        ns[2]  = ev_vbus  | (m_sts[2]  & ~clr[2]);
        ns[3]  = ev_wake  | (m_sts[3]  & ~clr[3]);
        ns[31] = ev_setup | (m_sts[31] & ~clr[31]);
        for (int n = 0; n < NEP; n++)
            ns[16+n] = (ok && ev_ep == 4'(n)) | (m_sts[16+n] & ~clr[1] & ~clr[16+n]);
        nw = m_epw;
        if (ok) begin
            nw[7:0] = {ev_ovr, ev_code, ev_ep};
            if (ev_ep < 4'(NEP)) nw[8 + 3*ev_ep +: 3] = ev_code;
        end
        m_en = ne; m_sts = ns; m_epw = nw;
    endtask

    task automatic cyc(input logic wr, input logic [1:0] a, input logic [31:0] d,
                       input logic b, input logic v, input logic w, input logic s,
                       input logic x, input logic [3:0] e, input logic [2:0] c,
                       input logic o);
        logic [31:0] r;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        ev_bus = b; ev_vbus = v; ev_wake = w; ev_setup = s;
        ev_xfer = x; ev_ep = e; ev_code = c; ev_ovr = o;
        @(posedge clk);
        model_step();
        #1;
        reg_wr = 0; ev_bus = 0; ev_vbus = 0; ev_wake = 0; ev_setup = 0; ev_xfer = 0;
        rd(2'd0, r); chk("R2 enable word", r, m_en);
        rd(2'd1, r); chk("R4 status word", r, m_sts);
        rd(2'd2, r); chk("R7 endpoint word", r, m_epw);
        chk("R9 irq", {31'd0, irq}, {31'd0, exp_irq()});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            ntot++; nbad++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", ntot, nbad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #0.5;
        rd(2'd0, r); chk("R1 enable reset", r, 32'h0);
        rd(2'd1, r); chk("R1 status reset", r, 32'h0);
        rd(2'd2, r); chk("R1 endpoint word reset", r, 32'h0);
        chk("R1 irq reset", {31'd0, irq}, 32'h0);

        // R2: only defined enable bits stick
        cyc(1, 2'd0, 32'hFFFF_7FFF, 0,0,0,0, 0,4'd0,3'd0,0);
        rd(2'd0, r); chk("R2 defined bits only", r, 32'h0000_010F);
        // R8: NAK dropped while report bit is 0
        cyc(0, 2'd0, 0, 0,0,0,0, 1,4'd2,3'b001,0);
        rd(2'd1, r); chk("R8 nak dropped status", r, 32'h0);
        rd(2'd2, r); chk("R8 nak dropped endpoint word", r, 32'h0);
        // R3 R7: OUT DATA1 on endpoint 2 with overrun
        cyc(0, 2'd0, 0, 0,0,0,0, 1,4'd2,3'b110,1);
        rd(2'd1, r); chk("R3 ep2 and summary", r, 32'h0004_0002);
        rd(2'd2, r); chk("R7 ep2 packing", r, 32'h0001_80E2);
        chk("R9 irq via usb enable", {31'd0, irq}, 32'h1);
        cyc(0, 2'd0, 0, 0,0,0,0, 1,4'd0,3'b011,0);
        rd(2'd2, r); chk("R7 ep0 packing", r, 32'h0001_8330);
        // R5: single endpoint clear, then summary clear
        cyc(1, 2'd1, 32'h0001_0000, 0,0,0,0, 0,4'd0,3'd0,0);
        rd(2'd1, r); chk("R5 ep0 alone cleared", r, 32'h0004_0002);
        cyc(1, 2'd1, 32'h0000_0002, 0,0,0,0, 0,4'd0,3'd0,0);
        rd(2'd1, r); chk("R5 summary clears endpoints", r, 32'h0);
        // R6: set and clear in same cycle
        cyc(1, 2'd1, 32'h8000_000F, 1,0,0,1, 0,4'd0,3'd0,0);
        rd(2'd1, r); chk("R6 set wins", r, 32'h8000_0001);
        // R10: endpoint word is read-only
        cyc(1, 2'd2, 32'hFFFF_FFFF, 0,0,0,0, 0,4'd0,3'd0,0);
        rd(2'd2, r); chk("R10 write ignored", r, 32'h0001_8330);
        rd(2'd3, r); chk("R10 word 3 reads zero", r, 32'h0);
        // R8: NAK accepted once reported
        cyc(1, 2'd0, 32'h0000_8000, 0,0,0,0, 0,4'd0,3'd0,0);
        cyc(0, 2'd0, 0, 0,0,0,0, 1,4'd5,3'b001,0);
        rd(2'd1, r); chk("R8 nak accepted status", r, 32'h8020_0003);
        rd(2'd2, r); chk("R8 nak accepted endpoint word", r, 32'h0081_8315);
        chk("R9 irq masked", {31'd0, irq}, 32'h0);
        // R11: index beyond endpoint count
        cyc(0, 2'd0, 0, 0,0,0,0, 1,4'd7,3'b111,0);
        rd(2'd1, r); chk("R11 no endpoint flag", r, 32'h8020_0003);
        rd(2'd2, r); chk("R11 last fields only", r, 32'h0081_8377);
        // R4: write zero then write ones
        cyc(1, 2'd1, 32'h0, 0,0,0,0, 0,4'd0,3'd0,0);
        rd(2'd1, r); chk("R4 write zero keeps", r, 32'h8020_0003);
        cyc(1, 2'd1, 32'hFFFF_FFFF, 0,0,0,0, 0,4'd0,3'd0,0);
        rd(2'd1, r); chk("R4 write ones clears", r, 32'h0);

        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom % 4) == 0, 2'($urandom % 4), $urandom,
                ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
                ($urandom % 8) == 0, ($urandom % 3) == 0, 4'($urandom % 8),
                3'($urandom % 8), 1'($urandom % 2));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end

endmodule